// File: doc/BRIEF.md
# Multichannel Codec Job Sequencer

This block is the control front end of a time-multiplexed speech codec. A client presents one coding request at a time: a direction (encode or decode), a channel number, format selects and the two input words. The block accepts it with a valid/busy handshake and latches every field. It looks up the channel's stored configuration, emits a one-cycle start pulse with the resolved channel and the effective law, inversion and code size, and then holds a fixed six-cycle coding window. When the window closes, it captures the datapath result into registered outputs. The transcoding datapath, the per-channel predictor state and the PCM expansion and compression sit outside the block.

A table inside the block holds one 8-bit configuration word per channel. After reset, the block sweeps the table and writes the configuration input into every entry, one entry per clock. A per-channel clear rewrites a single entry. A static mode pin selects how channels are addressed. In flexible mode every channel number stands alone. In duplex mode an even/odd pair shares one word: its upper nibble governs encoding and its lower nibble governs decoding.

The request interface follows valid/ready rules, with `busy` as the inverse of ready. A request is taken on the first rising edge where `req_valid` is high, `busy` is low and `clr` is low. While `busy` is high, `req_valid` and the request fields are ignored. The client may hold them, and the request is taken on the first edge after `busy` falls. A client that keeps `req_valid` high therefore gets back-to-back jobs, one every six edges.

Top module: `codec_job_seq`

## Requirements
- R1: While `rst_n` is low, `busy`, `enc_idle` and `dec_idle` are 1, `job_start` is 0, and `out_code` and `out_sample` are 0. Reset is asynchronous and aborts any job.
- R2: From the first rising edge after reset release, the block writes `cfg_in` into one table entry per edge, in ascending order, for NUM_CH edges. `busy` stays high for exactly NUM_CH cycles after release.
- R3: A request is accepted only on an edge where `req_valid` is 1, `busy` is 0 and `clr` is 0. `job_start` is 1 for exactly the cycle after that edge. A request presented while `busy` is 1 leaves every `job_*` output unchanged.
- R4: After an accepting edge, `busy` is high for five cycles and falls after the sixth edge of the job, counting the accepting edge as the first. A new request can be accepted on the next edge.
- R5: `enc_idle` (for encodes) or `dec_idle` (for decodes) goes to 0 in the cycle after acceptance and returns to 1 together with the result. The other flag does not change.
- R6: On acceptance, the block latches `req_enc`, `req_log_pcm`, `req_g726`, `req_ext_bits` and `req_sample` to the matching `job_*` outputs, which hold until the next acceptance.
- R7: A configuration nibble has this layout: bit 3 is the law (0 = mu-law, 1 = A-law), bit 2 enables bit inversion, and bits 1:0 set the code size (00 = 2, 01 = 3, 10 = 4, 11 = 5 bits). In flexible mode, the lower nibble of the entry addressed by `req_chan` drives `job_alaw`, `job_invert` and `job_size`.
- R8: In duplex mode, the table entry is `req_chan` with its LSB forced to 0. Encodes use the upper nibble (bits 7:4) and decodes use the lower nibble. `job_chan` is `req_chan` with its LSB replaced by 0 for encode and 1 for decode. In flexible mode `job_chan` equals `req_chan`.
- R9: On the sixth edge of a job, an encode loads `out_code` with `dp_code`, and a decode loads `out_sample` with `dp_sample`. Neither output changes on any other edge.
- R10: Codes are MSB-aligned in 5 bits, with bit 4 as the MSB. `job_code` and `out_code` keep only the top size+2 bits and clear the bits below them.
- R11: `clr` with `busy` low writes `cfg_in` into the entry addressed as in R7/R8, holds `busy` high for one cycle, and takes priority over a request on the same edge, so that request is not accepted. `clr` while `busy` is high is ignored.
- R12: Asserting `rst_n` low mid-job drives `busy` high and both status flags high at once, and a full sweep (R2) follows the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dup_mode | input | 1 | 1 = duplex addressing, 0 = flexible |
| cfg_in | input | 8 | Configuration word for the sweep and for clears |
| clr | input | 1 | Per-channel reset/configure strobe |
| req_valid | input | 1 | Coding request valid |
| req_enc | input | 1 | 1 = encode, 0 = decode |
| req_chan | input | CH_W | Channel number |
| req_log_pcm | input | 1 | PCM type select, passed to the datapath |
| req_g726 | input | 1 | Standard select, passed to the datapath |
| req_ext_bits | input | 2 | Enhancement-bit count, passed to the datapath |
| req_sample | input | 14 | PCM sample for encoding |
| req_code | input | 5 | ADPCM code for decoding |
| busy | output | 1 | Request not ready |
| enc_idle | output | 1 | Encode status, 0 while an encode runs |
| dec_idle | output | 1 | Decode status, 0 while a decode runs |
| job_start | output | 1 | One-cycle job start pulse |
| job_enc | output | 1 | Latched direction |
| job_chan | output | CH_W | Resolved channel index |
| job_alaw | output | 1 | Effective law |
| job_invert | output | 1 | Effective bit inversion |
| job_size | output | 2 | Effective code size |
| job_log_pcm | output | 1 | Latched PCM type |
| job_g726 | output | 1 | Latched standard select |
| job_ext_bits | output | 2 | Latched enhancement-bit count |
| job_sample | output | 14 | Latched sample |
| job_code | output | 5 | Latched, size-masked code |
| dp_code | input | 5 | Datapath encode result |
| dp_sample | input | 14 | Datapath decode result |
| out_code | output | 5 | Registered encode output |
| out_sample | output | 14 | Registered decode output |

## Verification
A per-channel clear and a coding request can both arrive on the same idle edge. The bench provokes this by raising `clr` and `req_valid` together. It judges the outcome by the absence of `job_start`, by one busy cycle, and by a later job on that channel that shows the newly written configuration. A strobe held across the finishing edge is a second collision: the result capture and the next acceptance must then fall on adjacent edges. The bench drives strobes continuously through consecutive windows, and a cycle-level reference model compares every output on every clock.

// File: rtl/cjs_pkg.sv
package cjs_pkg;

  localparam int CFG_W    = 8;
  localparam int CODE_W   = 5;
  localparam int SAMPLE_W = 14;

  // One half of a configuration word
  typedef struct packed {
    logic       alaw;
    logic       invert;
    logic [1:0] size;
  } cjs_nib_t;

  typedef enum logic [1:0] {
    ST_SWEEP,
    ST_IDLE,
    ST_RUN,
    ST_HOLD
  } cjs_state_t;

  // Keep the top size+2 bits of an MSB-aligned code
  function automatic logic [CODE_W-1:0] code_keep(input logic [1:0] size);
    return ~(5'b11111 >> ({1'b0, size} + 3'd2));
  endfunction

endpackage

// File: rtl/cjs_cfg_table.sv
module cjs_cfg_table #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Contents are defined by the post-reset sweep, so no reset here
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/cjs_chan_map.sv
module cjs_chan_map
  import cjs_pkg::*;
#(
  parameter int CH_W = 10
) (
  input  logic             dup,
  input  logic             enc,
  input  logic [CH_W-1:0]  chan,
  input  logic [CFG_W-1:0] entry,
  output logic [CH_W-1:0]  base,
  output logic [CH_W-1:0]  resolved,
  output cjs_nib_t         nib
);

  // Duplex pairs share the even entry; the resolved index separates directions
  assign base     = dup ? {chan[CH_W-1:1], 1'b0} : chan;
  assign resolved = dup ? {chan[CH_W-1:1], ~enc} : chan;
  assign nib      = (dup && enc) ? entry[7:4] : entry[3:0];

endmodule

// File: rtl/cjs_seq.sv
module cjs_seq
  import cjs_pkg::*;
#(
  parameter int NUM_CH     = 1024,
  parameter int CH_W       = 10,
  parameter int JOB_CYCLES = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            clr,
  output logic            busy,
  output logic            accept,
  output logic            clr_fire,
  output logic            finish,
  output logic            sweep_we,
  output logic [CH_W-1:0] sweep_idx
);

  localparam int CNT_W = $clog2(JOB_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(JOB_CYCLES - 2);
  localparam logic [CH_W-1:0]  IDX_LAST = CH_W'(NUM_CH - 1);

  cjs_state_t       st_q;
  logic [CH_W-1:0]  idx_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy      = (st_q != ST_IDLE);
  assign clr_fire  = (st_q == ST_IDLE) && clr;
  assign accept    = (st_q == ST_IDLE) && req_valid && !clr;
  assign finish    = (st_q == ST_RUN) && (cnt_q == CNT_LAST);
  assign sweep_we  = (st_q == ST_SWEEP);
  assign sweep_idx = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SWEEP;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_SWEEP: begin
          if (idx_q == IDX_LAST) st_q <= ST_IDLE;
          else                   idx_q <= idx_q + 1'b1;
        end
        ST_IDLE: begin
          if (clr) begin
            st_q <= ST_HOLD;
          end else if (req_valid) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
          end
        end
        ST_RUN: begin
          if (cnt_q == CNT_LAST) st_q <= ST_IDLE;
          else                   cnt_q <= cnt_q + 1'b1;
        end
        ST_HOLD: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/codec_job_seq.sv
module codec_job_seq
  import cjs_pkg::*;
#(
  parameter int NUM_CH     = 1024,
  parameter int JOB_CYCLES = 6,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dup_mode,
  input  logic [CFG_W-1:0]    cfg_in,
  input  logic                clr,
  input  logic                req_valid,
  input  logic                req_enc,
  input  logic [CH_W-1:0]     req_chan,
  input  logic                req_log_pcm,
  input  logic                req_g726,
  input  logic [1:0]          req_ext_bits,
  input  logic [SAMPLE_W-1:0] req_sample,
  input  logic [CODE_W-1:0]   req_code,
  output logic                busy,
  output logic                enc_idle,
  output logic                dec_idle,
  output logic                job_start,
  output logic                job_enc,
  output logic [CH_W-1:0]     job_chan,
  output logic                job_alaw,
  output logic                job_invert,
  output logic [1:0]          job_size,
  output logic                job_log_pcm,
  output logic                job_g726,
  output logic [1:0]          job_ext_bits,
  output logic [SAMPLE_W-1:0] job_sample,
  output logic [CODE_W-1:0]   job_code,
  input  logic [CODE_W-1:0]   dp_code,
  input  logic [SAMPLE_W-1:0] dp_sample,
  output logic [CODE_W-1:0]   out_code,
  output logic [SAMPLE_W-1:0] out_sample
);

  logic             accept, clr_fire, finish, sweep_we;
  logic [CH_W-1:0]  sweep_idx, base, resolved;
  logic [CFG_W-1:0] entry;
  cjs_nib_t         nib;

  cjs_seq #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .JOB_CYCLES(JOB_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .clr(clr),
    .busy(busy), .accept(accept), .clr_fire(clr_fire), .finish(finish),
    .sweep_we(sweep_we), .sweep_idx(sweep_idx)
  );

  cjs_chan_map #(.CH_W(CH_W)) u_map (
    .dup(dup_mode), .enc(req_enc), .chan(req_chan), .entry(entry),
    .base(base), .resolved(resolved), .nib(nib)
  );

  cjs_cfg_table #(.DEPTH(NUM_CH), .AW(CH_W), .DW(CFG_W)) u_tbl (
    .clk(clk),
    .we(sweep_we || clr_fire),
    .waddr(sweep_we ? sweep_idx : base),
    .wdata(cfg_in),
    .raddr(base),
    .rdata(entry)
  );

  // Request latch: the effective configuration is frozen at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      job_start    <= 1'b0;
      job_enc      <= 1'b0;
      job_chan     <= '0;
      job_alaw     <= 1'b0;
      job_invert   <= 1'b0;
      job_size     <= '0;
      job_log_pcm  <= 1'b0;
      job_g726     <= 1'b0;
      job_ext_bits <= '0;
      job_sample   <= '0;
      job_code     <= '0;
    end else begin
      job_start <= accept;
      if (accept) begin
        job_enc      <= req_enc;
        job_chan     <= resolved;
        job_alaw     <= nib.alaw;
        job_invert   <= nib.invert;
        job_size     <= nib.size;
        job_log_pcm  <= req_log_pcm;
        job_g726     <= req_g726;
        job_ext_bits <= req_ext_bits;
        job_sample   <= req_sample;
        job_code     <= req_code & code_keep(nib.size);
      end
    end
  end

  // Status flags and result capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_idle   <= 1'b1;
      dec_idle   <= 1'b1;
      out_code   <= '0;
      out_sample <= '0;
    end else begin
      if (accept && req_enc)       enc_idle <= 1'b0;
      else if (finish && job_enc)  enc_idle <= 1'b1;
      if (accept && !req_enc)      dec_idle <= 1'b0;
      else if (finish && !job_enc) dec_idle <= 1'b1;
      if (finish) begin
        if (job_enc) out_code   <= dp_code & code_keep(job_size);
        else         out_sample <= dp_sample;
      end
    end
  end

endmodule

// File: rtl/cjs_checker.sv
module cjs_checker #(
  parameter int CH_W       = 10,
  parameter int JOB_CYCLES = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            clr,
  input logic            busy,
  input logic            job_start,
  input logic            enc_idle,
  input logic            dec_idle,
  input logic [CH_W-1:0] job_chan,
  input logic [4:0]      job_code,
  input logic [4:0]      out_code,
  input logic [13:0]     out_sample
);

  // Counts busy cycles since the last start pulse
  logic [7:0] win_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    win_q <= '0;
    else if (job_start)            win_q <= 8'd1;
    else if (win_q != '0 && busy)  win_q <= win_q + 8'd1;
    else                           win_q <= '0;
  end

  a_r3_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !clr && !busy) |=> job_start);

  a_r3_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !job_start);

  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |-> busy);

  a_r4_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != '0 && !busy) |-> (win_q == 8'(JOB_CYCLES - 1)));

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!enc_idle && !dec_idle));

  a_r5_flag_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!enc_idle || !dec_idle) |-> busy);

  a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !job_start) |-> ($stable(job_chan) && $stable(job_code)));

  a_r9_out_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(out_code) || !$stable(out_sample)) |-> $fell(busy));

  a_r11_clr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !busy) |=> (busy && !job_start));

endmodule

bind codec_job_seq cjs_checker #(.CH_W(CH_W), .JOB_CYCLES(JOB_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .clr(clr), .busy(busy),
  .job_start(job_start), .enc_idle(enc_idle), .dec_idle(dec_idle),
  .job_chan(job_chan), .job_code(job_code), .out_code(out_code),
  .out_sample(out_sample)
);

// File: tb/tb_codec_job_seq.sv
`timescale 1ns/1ps
module tb_codec_job_seq;
  localparam int NCH = 16;
  localparam int CHW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic dup_mode = 1'b0, clr = 1'b0, req_valid = 1'b0, req_enc = 1'b0;
  logic req_log_pcm = 1'b0, req_g726 = 1'b0;
  logic [1:0] req_ext_bits = '0;
  logic [7:0] cfg_in = 8'hA6;
  logic [CHW-1:0] req_chan = '0;
  logic [13:0] req_sample = '0;
  logic [4:0] req_code = '0;
  logic [4:0] dp_code, out_code, job_code;
  logic [13:0] dp_sample, out_sample, job_sample;
  logic busy, enc_idle, dec_idle, job_start, job_enc, job_alaw, job_invert;
  logic job_log_pcm, job_g726;
  logic [1:0] job_size, job_ext_bits;
  logic [CHW-1:0] job_chan;

  codec_job_seq #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .dup_mode(dup_mode), .cfg_in(cfg_in), .clr(clr),
    .req_valid(req_valid), .req_enc(req_enc), .req_chan(req_chan),
    .req_log_pcm(req_log_pcm), .req_g726(req_g726), .req_ext_bits(req_ext_bits),
    .req_sample(req_sample), .req_code(req_code), .busy(busy),
    .enc_idle(enc_idle), .dec_idle(dec_idle), .job_start(job_start),
    .job_enc(job_enc), .job_chan(job_chan), .job_alaw(job_alaw),
    .job_invert(job_invert), .job_size(job_size), .job_log_pcm(job_log_pcm),
    .job_g726(job_g726), .job_ext_bits(job_ext_bits), .job_sample(job_sample),
    .job_code(job_code), .dp_code(dp_code), .dp_sample(dp_sample),
    .out_code(out_code), .out_sample(out_sample)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // Datapath stand-in: results change every cycle, so the capture edge is visible
  always @(negedge clk) cyc++;
  assign dp_code   = 5'(cyc * 3 + 1);
  assign dp_sample = 14'(cyc * 37 + 5);

  task automatic cmp(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit [4:0] msk(input bit [1:0] s);
    bit [4:0] m = '0;
    for (int i = 0; i < 5; i++) if (i >= 3 - int'(s)) m[i] = 1'b1;
    return m;
  endfunction

  // Behavioural reference: phase 0 sweep, 1 idle, 2 job, 3 clear hold
  bit [7:0] tbl [NCH];
  int phase = 0, idx = 0, cnt = 0, b = 0;
  bit [7:0] e;
  bit [3:0] n;
  bit ms = 0, me_idle = 1, md_idle = 1, menc = 0, mlaw = 0, minv = 0, mlog = 0, mg = 0;
  bit [1:0] msize = 0, mext = 0;
  bit [CHW-1:0] mchan = 0;
  bit [13:0] msamp = 0, mout_s = 0;
  bit [4:0] mcode = 0, mout_c = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; idx = 0; cnt = 0; ms = 0; me_idle = 1; md_idle = 1;
      menc = 0; mchan = 0; mlaw = 0; minv = 0; msize = 0; mlog = 0; mg = 0;
      mext = 0; msamp = 0; mcode = 0; mout_c = 0; mout_s = 0;
    end else begin
      ms = 0;
      case (phase)
        0: begin
          tbl[idx] = cfg_in;
          if (idx == NCH - 1) phase = 1; else idx++;
        end
        1: begin
          b = dup_mode ? (int'(req_chan) / 2) * 2 : int'(req_chan);
          if (clr) begin
            tbl[b] = cfg_in; phase = 3;
          end else if (req_valid) begin
            e = tbl[b];
            n = (dup_mode && req_enc) ? e[7:4] : e[3:0];
            menc = req_enc; mlaw = n[3]; minv = n[2]; msize = n[1:0];
            mchan = dup_mode ? CHW'(b + (req_enc ? 0 : 1)) : req_chan;
            mlog = req_log_pcm; mg = req_g726; mext = req_ext_bits;
            msamp = req_sample; mcode = req_code & msk(n[1:0]);
            ms = 1; phase = 2; cnt = 1;
            if (req_enc) me_idle = 0; else md_idle = 0;
          end
        end
        2: begin
          if (cnt == 5) begin
            if (menc) begin mout_c = dp_code & msk(msize); me_idle = 1; end
            else begin mout_s = dp_sample; md_idle = 1; end
            phase = 1;
          end else cnt++;
        end
        default: phase = 1;
      endcase
    end
  end

  always @(negedge clk) if (!done) begin
    cmp(phase == 0 ? "R2" : "R4", "busy", busy, phase != 1);
    cmp("R5", "enc_idle", enc_idle, me_idle);
    cmp("R5", "dec_idle", dec_idle, md_idle);
    cmp("R3", "job_start", job_start, ms);
    cmp("R6", "job_enc", job_enc, menc);
    cmp("R8", "job_chan", job_chan, mchan);
    cmp("R7", "job_alaw", job_alaw, mlaw);
    cmp("R7", "job_invert", job_invert, minv);
    cmp("R7", "job_size", job_size, msize);
    cmp("R6", "job_log_pcm", job_log_pcm, mlog);
    cmp("R6", "job_g726", job_g726, mg);
    cmp("R6", "job_ext_bits", job_ext_bits, mext);
    cmp("R6", "job_sample", job_sample, msamp);
    cmp("R10", "job_code", job_code, mcode);
    cmp("R9", "out_code", out_code, mout_c);
    cmp("R9", "out_sample", out_sample, mout_s);
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic do_job(input bit enc, input int ch, input bit [4:0] code, input bit [13:0] smp);
    wait_idle();
    @(posedge clk); #1;
    req_valid = 1; req_enc = enc; req_chan = CHW'(ch); req_code = code; req_sample = smp;
    req_log_pcm = ~req_log_pcm; req_g726 = enc; req_ext_bits = req_ext_bits + 2'd1;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic do_clr(input int ch, input bit [7:0] cfg);
    wait_idle();
    @(posedge clk); #1;
    clr = 1; req_chan = CHW'(ch); cfg_in = cfg;
    @(posedge clk); #1;
    clr = 0;
    @(negedge clk);
    cmp("R11", "busy after clear", busy, 1);
    cmp("R11", "no start on clear", job_start, 0);
  endtask

  initial begin
    @(posedge clk); #1;
    cmp("R1", "busy in reset", busy, 1);
    cmp("R1", "enc_idle in reset", enc_idle, 1);
    cmp("R1", "dec_idle in reset", dec_idle, 1);
    cmp("R1", "job_start in reset", job_start, 0);
    cmp("R1", "out_code in reset", out_code, 0);
    cmp("R1", "out_sample in reset", out_sample, 0);
    @(posedge clk); #1;
    rst_n = 1;
    begin
      int nb = 0;
      @(negedge clk);
      while (busy) begin nb++; @(negedge clk); end
      cmp("R2", "sweep busy cycles", nb, NCH);
    end
    cfg_in = 8'h00;

    // Flexible mode, reading back the swept configuration
    do_job(1, 3, 5'h1F, 14'h1234);
    do_job(0, 7, 5'h15, 14'h0042);

    // Strobe held while busy with different fields
    do_job(1, 2, 5'h0E, 14'h0777);
    req_valid = 1; req_chan = 4'd9; req_enc = 0; req_sample = 14'h3FFF;
    repeat (3) begin @(posedge clk); #1; end
    req_valid = 0;
    @(negedge clk);
    cmp("R3", "chan unchanged by busy strobe", job_chan, 2);
    cmp("R3", "sample unchanged by busy strobe", job_sample, 14'h0777);

    // Back-to-back jobs with a held strobe
    wait_idle();
    @(posedge clk); #1;
    req_valid = 1;
    repeat (13) begin
      @(posedge clk); #1;
      req_sample = req_sample + 14'd1; req_enc = ~req_enc; req_chan = req_chan + 1'b1;
      req_code = req_code + 5'd7;
    end
    req_valid = 0;

    // Per-channel clear, then a job on that channel
    do_clr(5, 8'h3F);
    do_job(0, 5, 5'h1F, 14'h0001);

    // Clear and request on the same edge: clear wins
    wait_idle();
    @(posedge clk); #1;
    clr = 1; req_valid = 1; req_chan = 4'd6; cfg_in = 8'h04;
    @(posedge clk); #1;
    clr = 0; req_valid = 0;
    @(negedge clk);
    cmp("R11", "request dropped on clear edge", job_start, 0);
    cmp("R11", "busy on clear edge", busy, 1);

    // Clear while busy is ignored
    do_job(1, 6, 5'h1B, 14'h0100);
    clr = 1; cfg_in = 8'h0B; req_chan = 4'd6;
    @(posedge clk); #1;
    clr = 0;
    do_job(1, 6, 5'h1F, 14'h0101);
    @(negedge clk);
    cmp("R11", "size kept after ignored clear", job_size, 0);

    // Duplex pair sharing one word
    wait_idle();
    dup_mode = 1;
    do_clr(9, 8'h1C);
    do_job(1, 8, 5'h1F, 14'h0200);
    do_job(0, 9, 5'h17, 14'h0201);
    @(negedge clk);
    cmp("R8", "decode resolved index", job_chan, 9);
    cmp("R8", "decode lower nibble law", job_alaw, 1);
    do_job(1, 9, 5'h1F, 14'h0202);
    @(negedge clk);
    cmp("R8", "encode resolved index", job_chan, 8);
    cmp("R8", "encode upper nibble size", job_size, 1);

    // Reset in the middle of a job
    cfg_in = 8'hE5;
    do_job(1, 4, 5'h1F, 14'h0300);
    @(posedge clk); #1;
    rst_n = 0;
    #1;
    cmp("R12", "busy on abort", busy, 1);
    cmp("R12", "enc_idle on abort", enc_idle, 1);
    cmp("R12", "dec_idle on abort", dec_idle, 1);
    @(posedge clk); #1;
    rst_n = 1;
    do_job(1, 4, 5'h1F, 14'h0301);
    do_job(0, 11, 5'h1F, 14'h0302);
    wait_idle();
    repeat (8) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule